// File: doc/BRIEF.md
# Counter-Based Hit Timestamp Channel

This block is one channel of a coarse time-to-digital converter that runs at 250 MHz, so one count is 4 ns. It takes one asynchronous discriminator output. It passes that input through a two-flop synchroniser and finds its rising edges. On each rising edge it latches the value of a free-running 8-bit time counter, then writes that value into a 16-entry first-in first-out store kept for this channel alone. The time counter is shared in spirit across many channels. A synchronous clear input returns it to zero, so that every channel and board that sees the same clear measures from the same origin.

A collector that sweeps many channels reads the store through a read-enable, a data bus and an empty flag. The oldest timestamp is always on the data bus while the store is not empty, and a read-enable pulse removes it. The collector shares the channel's clock and may pulse read-enable at any rate it likes, for example every second cycle. When the store is full, a new hit is discarded and a sticky overflow flag records the loss. Stored timestamps are never overwritten.

Top module: `tdc_channel`

## Requirements
- R1: While reset is high and on the first cycle after it, empty is 1, full is 0 and overflow is 0.
- R2: The time counter becomes 0 on every clock edge where the clear input is 1. On every other edge it adds one, and it wraps from 255 to 0. A rising input edge first sampled at the k-th clock edge after a clear edge (k at least 1) is stored as the timestamp (k+1) mod 256.
- R3: A hit that arrives while the store holds 16 entries is dropped, and overflow goes to 1. Overflow stays at 1 until reset, even after the store is read empty. The 16 stored entries stay intact and in their order.
- R4: Empty falls after exactly four clock edges, counted from the first edge that samples the input high. After three of those edges it is still 1.
- R5: An input held high for many cycles produces exactly one stored timestamp.
- R6: Two input pulses whose rising edges are sampled two clock edges apart (high, low, high on consecutive edges) produce two entries, with timestamps that differ by 2.
- R7: A clear sampled on the same edge as a capture leaves that capture with the counter value from before the clear. The counter restarts from 0 on that same edge.
- R8: The read data shows the oldest stored timestamp whenever empty is 0, and a read-enable pulse removes exactly that entry. A read-enable while empty is 0... is ignored when empty is 1: it changes neither the pointers nor the next stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 250 MHz channel clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 1 | Asynchronous discriminator output |
| cnt_clr | input | 1 | Synchronous clear of the time counter |
| rd_en | input | 1 | Removes the oldest stored timestamp |
| rd_data | output | 8 | Oldest stored timestamp |
| empty | output | 1 | Store holds no timestamp |
| full | output | 1 | Store holds 16 timestamps |
| overflow | output | 1 | Sticky flag: a hit was dropped because the store was full |

## Verification
A counter clear and a timestamp capture can fall on the same clock edge. This matters because the capture register and the counter both update on that edge. The bench sets up this case by raising the input and then asserting the clear so that it is sampled on the third edge after the input rose, which is the capture edge. It then judges the result through two timestamps. The first must carry the count from before the clear. A second hit, raised a known number of cycles later, must carry a count measured from the new origin.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int TS_W       = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int SYNC_LEN   = 2;

    typedef logic [TS_W-1:0] stamp_t;

    typedef struct packed {
        logic   vld;
        stamp_t ts;
    } capture_t;

    function automatic stamp_t stamp_next(input stamp_t cur);
        return stamp_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
    parameter int STAGES = tdc_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tdc_timebase.sv
module tdc_timebase
    import tdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    output stamp_t count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else            count <= stamp_next(count);
    end
endmodule

// File: rtl/tdc_stamp_fifo.sv
module tdc_stamp_fifo
    import tdc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  stamp_t wr_data,
    input  logic   rd_en,
    output stamp_t rd_data,
    output logic   empty,
    output logic   full,
    output logic   overflow
);
    localparam int AW = $clog2(DEPTH);

    stamp_t      mem [DEPTH];
    logic [AW:0] wp_q, rp_q;
    logic        do_wr, do_rd;

    assign empty   = (wp_q == rp_q);
    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            rp_q     <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            if (wr_en && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
    import tdc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit_in,
    input  logic            cnt_clr,
    input  logic            rd_en,
    output logic [TS_W-1:0] rd_data,
    output logic            empty,
    output logic            full,
    output logic            overflow
);
    logic     rise;
    stamp_t   count;
    capture_t cap_q;
    logic     cap_vld;

    tdc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .async_in(hit_in), .rise(rise)
    );

    tdc_timebase u_time (
        .clk(clk), .rst(rst), .clr(cnt_clr), .count(count)
    );

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= '{vld: rise, ts: count};
    end

    assign cap_vld = cap_q.vld;

    tdc_stamp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(cap_vld), .wr_data(cap_q.ts),
        .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .full(full), .overflow(overflow)
    );
endmodule

// File: rtl/tdc_channel_chk.sv
module tdc_channel_chk
    import tdc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cnt_clr,
    input logic   rd_en,
    input stamp_t rd_data,
    input logic   empty,
    input logic   full,
    input logic   overflow,
    input logic   cap_vld,
    input stamp_t count
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !overflow));

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (count == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (count == stamp_t'($past(count) + 1'b1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(full));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_single_capture_r5: assert property (@(posedge clk) disable iff (rst)
        cap_vld |=> !cap_vld);

    p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!empty && !rd_en) |=> ($stable(rd_data) && !empty));

    p_full_not_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
endmodule

bind tdc_channel tdc_channel_chk u_chk (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow),
    .cap_vld(cap_vld), .count(count)
);

// File: tb/test_tdc_channel.sv
`timescale 1ns/1ps
module test_tdc_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_in = 1'b0;
    logic       cnt_clr = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty, full, overflow;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int NVEC = 6;
    localparam int GAP_TAB [NVEC] = '{0, 5, 37, 253, 254, 300};
    localparam int EXP_TAB [NVEC] = '{2, 7, 39, 255, 0, 46};

    always #2 clk = ~clk;

    tdc_channel i_tdc_channel (
        .clk(clk), .rst(rst), .hit_in(hit_in), .cnt_clr(cnt_clr),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .overflow(overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_edge();
        cnt_clr = 1'b1;
        tick(1);
        cnt_clr = 1'b0;
    endtask

    task automatic pop_expect(input string req, input int exp);
        check({req, " not empty"}, int'(empty), 0);
        check({req, " data"}, int'(rd_data), exp);
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 empty in reset", int'(empty), 1);
        check("R1 overflow in reset", int'(overflow), 0);
        rst = 1'b0;
        tick(1);
        check("R1 empty after reset", int'(empty), 1);
        check("R1 full after reset", int'(full), 0);
        check("R1 overflow after reset", int'(overflow), 0);

        // R2 / R4: table walk, timestamp relative to clear and wrap
        for (int v = 0; v < NVEC; v++) begin
            clear_edge();
            if (GAP_TAB[v] > 0) tick(GAP_TAB[v]);
            hit_in = 1'b1;
            tick(3);
            check("R4 still empty after three edges", int'(empty), 1);
            tick(1);
            check("R4 visible after four edges", int'(empty), 0);
            hit_in = 1'b0;
            tick(2);
            pop_expect("R2 timestamp", EXP_TAB[v]);
            check("R2 single entry", int'(empty), 1);
        end

        // R5: long high level gives one entry
        clear_edge();
        hit_in = 1'b1;
        tick(20);
        hit_in = 1'b0;
        tick(4);
        pop_expect("R5 held level", 2);
        check("R5 no second entry", int'(empty), 1);

        // R6: rises two edges apart
        clear_edge();
        hit_in = 1'b1; tick(1);
        hit_in = 1'b0; tick(1);
        hit_in = 1'b1; tick(1);
        hit_in = 1'b0; tick(6);
        pop_expect("R6 first pulse", 2);
        pop_expect("R6 second pulse", 4);
        check("R6 only two", int'(empty), 1);

        // R7: clear on the capture edge
        clear_edge();
        hit_in = 1'b1;
        tick(2);
        hit_in  = 1'b0;
        cnt_clr = 1'b1;
        tick(1);
        cnt_clr = 1'b0;
        tick(5);
        hit_in = 1'b1;
        tick(2);
        hit_in = 1'b0;
        tick(4);
        pop_expect("R7 pre-clear value", 2);
        pop_expect("R7 restarted origin", 7);

        // R8: read while empty is ignored
        check("R8 empty before idle reads", int'(empty), 1);
        rd_en = 1'b1;
        tick(3);
        rd_en = 1'b0;
        check("R8 still empty", int'(empty), 1);
        clear_edge();
        tick(9);
        hit_in = 1'b1; tick(2);
        hit_in = 1'b0; tick(4);
        pop_expect("R8 after idle reads", 11);
        check("R8 empty after pop", int'(empty), 1);

        // R3: fill, then overflow
        clear_edge();
        for (int k = 0; k < 16; k++) begin
            hit_in = 1'b1; tick(1);
            hit_in = 1'b0; tick(1);
        end
        tick(6);
        check("R3 full at sixteen", int'(full), 1);
        check("R3 no overflow yet", int'(overflow), 0);
        hit_in = 1'b1; tick(1);
        hit_in = 1'b0; tick(6);
        check("R3 overflow set", int'(overflow), 1);
        check("R3 still full", int'(full), 1);
        for (int k = 0; k < 16; k++) begin
            pop_expect("R3 kept entry", 2 + 2 * k);
        end
        check("R3 dropped hit absent", int'(empty), 1);
        check("R3 overflow sticky", int'(overflow), 1);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(1);
        check("R1 overflow cleared by reset", int'(overflow), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule